// File: doc/BRIEF.md
# Tiered Prefix-Code Character Encoder

This block turns a stream of 7-bit characters into a packed bitstream. Each character is replaced by a code of fixed width for its tier, and the first two bits of the code name the tier. Eight characters picked by the user form the core tier. Each one becomes a 5-bit code. A fixed set of 64 printable characters forms the mid tier, with 8-bit codes. Every other character is sent as a 9-bit literal.

A frame opens when `start` is pulsed while the block is idle. On that pulse the block captures the 8-entry core table and the 32-bit payload bit count. It then sends a 12-byte header: the eight table characters, followed by the bit count. After the header it accepts characters one byte at a time. It packs their codes MSB first into output bytes. The character flagged `in_last` closes the frame. The block then drains the remaining bits, zero-pads the final byte and raises `out_last` on it. Counting character frequencies and filling in the bit count are left to the user.

Top module: `tier_code_packer`

## Requirements
- R1: The first 8 header bytes are the core-table entries, entry 0 first. Entry i sits in `core_tab[8*i+7:8*i]`. Each header byte carries the entry's low 7 bits with bit 7 forced to 0.
- R2: Header bytes 8 to 11 carry `bit_total`, most significant byte first.
- R3: A character that matches a core entry is coded as `01` followed by the 3-bit entry index. The core tier wins over the mid tier. If a character appears more than once in the table, the lowest matching index is used.
- R4: A character in 0x20..0x5F that is not in the core table is coded as `10` followed by the 6 bits of (character - 0x20).
- R5: Any other character is coded as `11` followed by its 7-bit value. The prefix `00` never appears.
- R6: Codes are packed MSB first and back to back, across byte boundaries, directly after the header.
- R7: The last output byte of a frame is zero-padded below its final code bit. `out_last` is high on that byte only.
- R8: While `out_valid` is high and `out_ready` is low, `out_data`, `out_valid` and `out_last` hold their values.
- R9: `in_ready` is low during the header and whenever 8 or more packed bits are waiting. Bit 7 of `in_data` is ignored.
- R10: The table and bit count are captured at `start`. Later changes to `core_tab` and `bit_total` have no effect on the current frame.
- R11: After reset, and whenever the block is idle, `out_valid` and `in_ready` are low.
- R12: A payload made only of core-tier characters takes 5 bits per character. For example, 16 such characters give 10 payload bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Frame start pulse, honoured only when idle |
| core_tab | input | 64 | Eight core characters, entry i in byte i |
| bit_total | input | 32 | Payload bit count placed in the header |
| in_data | input | 8 | Input character, low 7 bits used |
| in_valid | input | 1 | Input character valid |
| in_last | input | 1 | Marks the final character of the frame |
| in_ready | output | 1 | Block accepts a character this cycle |
| out_data | output | 8 | Output byte |
| out_valid | output | 1 | Output byte valid |
| out_last | output | 1 | Final byte of the frame |
| out_ready | input | 1 | Downstream accepts the byte |

## Verification
The first directed frame is a 16-character sequence drawn only from core characters. It shows that core codes take 5 bits each and that the payload is 10 bytes. A short mid-tier frame ends exactly on a byte boundary, so it separates correct `out_last` placement from an extra padding byte. A frame of outliers (lowercase letters, 0x00, 0x7F) exercises the 9-bit literal path. The core table includes characters that also lie in the mid range, such as 'A' and '0', so the priority between tiers is tested. Random frames with random tables, random input gaps, random output stalls and a random bit 7 on every input byte then stress packing across byte boundaries, backpressure and the capture of the configuration at `start`.

// File: rtl/tier_code_packer.sv
module tier_code_packer #(
  parameter int TAB_N    = 8,
  parameter logic [6:0] MID_BASE = 7'h20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [63:0] core_tab,
  input  logic [31:0] bit_total,
  input  logic [7:0]  in_data,
  input  logic        in_valid,
  input  logic        in_last,
  output logic        in_ready,
  output logic [7:0]  out_data,
  output logic        out_valid,
  output logic        out_last,
  input  logic        out_ready
);
  localparam int HDR_N = TAB_N + 4;

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_PAY, S_FLUSH} st_t;

  st_t         st;
  logic [63:0] core_q;
  logic [31:0] total_q;
  logic [3:0]  hidx;
  logic [15:0] acc;
  logic [4:0]  cnt;

  logic [6:0]  ch;
  logic        hit_core, hit_mid;
  logic [2:0]  core_idx;
  logic [5:0]  mid_idx;
  logic [8:0]  code_v;
  logic [3:0]  code_len;
  logic [15:0] ins;
  logic [7:0]  hdr_byte;

  assign ch      = in_data[6:0];
  assign mid_idx = 6'(ch - MID_BASE);
  assign hit_mid = (ch >= MID_BASE) && (ch <= MID_BASE + 7'd63);

  always_comb begin
    hit_core = 1'b0;
    core_idx = '0;
    for (int i = TAB_N - 1; i >= 0; i--) begin
      if (core_q[i*8 +: 7] == ch) begin
        hit_core = 1'b1;
        core_idx = 3'(i);
      end
    end
  end

  always_comb begin
    if (hit_core) begin
      code_v   = {4'b0, 2'b01, core_idx};
      code_len = 4'd5;
    end else if (hit_mid) begin
      code_v   = {1'b0, 2'b10, mid_idx};
      code_len = 4'd8;
    end else begin
      code_v   = {2'b11, ch};
      code_len = 4'd9;
    end
  end

  assign ins = ({code_v, 7'b0} << (4'd9 - code_len)) >> cnt;

  assign hdr_byte = (hidx < 4'(TAB_N)) ? {1'b0, core_q[{hidx[2:0], 3'b000} +: 7]}
                                       : total_q[{~hidx[1:0], 3'b000} +: 8];

  assign out_valid = (st == S_HDR) || (st == S_PAY && cnt >= 5'd8) ||
                     (st == S_FLUSH && cnt != 5'd0);
  assign out_data  = (st == S_HDR) ? hdr_byte : acc[15:8];
  assign out_last  = (st == S_FLUSH) && (cnt != 5'd0) && (cnt <= 5'd8);
  assign in_ready  = (st == S_PAY) && (cnt < 5'd8);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      core_q  <= '0;
      total_q <= '0;
      hidx    <= '0;
      acc     <= '0;
      cnt     <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          core_q  <= core_tab;
          total_q <= bit_total;
          hidx    <= '0;
          acc     <= '0;
          cnt     <= '0;
          st      <= S_HDR;
        end
        S_HDR: if (out_ready) begin
          hidx <= hidx + 4'd1;
          if (hidx == 4'(HDR_N - 1)) st <= S_PAY;
        end
        S_PAY: begin
          if (in_valid && in_ready) begin
            acc <= acc | ins;
            cnt <= cnt + 5'(code_len);
            if (in_last) st <= S_FLUSH;
          end else if (out_valid && out_ready) begin
            acc <= acc << 8;
            cnt <= cnt - 5'd8;
          end
        end
        S_FLUSH: if (out_valid && out_ready) begin
          if (cnt <= 5'd8) begin
            acc <= '0;
            cnt <= '0;
            st  <= S_IDLE;
          end else begin
            acc <= acc << 8;
            cnt <= cnt - 5'd8;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tier_code_packer_chk.sv
module tier_code_packer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_last,
  input logic [1:0] st,
  input logic [4:0] cnt
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R8
  AST_IN_OUT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid)); // R9
  AST_HDR_NO_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    st == 2'd1 |-> !in_ready); // R9
  AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid); // R7
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 5'd16); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    st == 2'd0 |-> !out_valid && !in_ready); // R11
endmodule

bind tier_code_packer tier_code_packer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
  .st(st), .cnt(cnt)
);

// File: tb/tier_code_packer_tb_top.sv
`timescale 1ns/1ps
module tier_code_packer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] core_tab = '0;
  logic [31:0] bit_total = '0;
  logic [7:0]  in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_last = 1'b0;
  logic        in_ready;
  logic [7:0]  out_data;
  logic        out_valid;
  logic        out_last;
  logic        out_ready = 1'b0;

  int checks = 0;
  int errors = 0;

  logic [6:0]  tab [0:7];
  logic [6:0]  fch [0:63];
  logic [7:0]  exp_b [0:127];
  int          exp_n;
  int          pbits;

  always #2.5 clk = ~clk;

  tier_code_packer dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .core_tab(core_tab),
    .bit_total(bit_total), .in_data(in_data), .in_valid(in_valid),
    .in_last(in_last), .in_ready(in_ready), .out_data(out_data),
    .out_valid(out_valid), .out_last(out_last), .out_ready(out_ready)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic void code_of(input logic [6:0] c, output logic [8:0] v, output int len);
    int hit = -1;
    for (int i = 7; i >= 0; i--) if (tab[i] == c) hit = i;
    if (hit >= 0) begin v = {4'b0, 2'b01, 3'(hit)}; len = 5; end
    else if (c >= 7'h20 && c <= 7'h5F) begin v = {1'b0, 2'b10, 6'(c - 7'h20)}; len = 8; end
    else begin v = {2'b11, c}; len = 9; end
  endfunction

  function automatic void build(input int n);
    logic [8:0] v;
    int len;
    int nb = 0;
    logic bits [0:1023];
    for (int i = 0; i < 8; i++) exp_b[i] = {1'b0, tab[i]};
    for (int i = 0; i < n; i++) begin
      code_of(fch[i], v, len);
      for (int k = len - 1; k >= 0; k--) begin bits[nb] = v[k]; nb++; end
    end
    pbits = nb;
    for (int i = 0; i < 4; i++) exp_b[8+i] = 8'(nb >> (8*(3-i)));
    exp_n = 12 + (nb + 7) / 8;
    for (int b = 0; b < (nb + 7) / 8; b++) begin
      logic [7:0] x = '0;
      for (int k = 0; k < 8; k++) x[7-k] = (b*8 + k < nb) ? bits[b*8 + k] : 1'b0;
      exp_b[12+b] = x;
    end
  endfunction

  task automatic run_frame(input int n, input string tag);
    logic [63:0] pack;
    int idx = 0, got = 0;
    bit done = 0, stalled = 0;
    logic [7:0] sdat = '0;
    string req;
    build(n);
    for (int i = 0; i < 8; i++) pack[i*8 +: 8] = {1'($urandom), tab[i]};
    @(posedge clk); #1;
    start = 1'b1; core_tab = pack; bit_total = 32'(pbits);
    @(posedge clk); #1;
    start = 1'b0; core_tab = ~pack; bit_total = ~32'(pbits); // R10
    while (!done) begin
      @(negedge clk);
      if (stalled) check(out_valid && out_data == sdat, "R8", int'(out_data), int'(sdat));
      if (got < 12) check(!in_ready, "R9", int'(in_ready), 0);
      if (in_valid && in_ready) idx++;
      if (out_valid && out_ready) begin
        req = (got < 8) ? "R1" : (got < 12) ? "R2" : "R6";
        if (got < exp_n) check(out_data == exp_b[got], req, int'(out_data), int'(exp_b[got]));
        check(out_last == (got == exp_n - 1), "R7", int'(out_last), int'(got == exp_n - 1));
        got++;
        if (out_last || got > exp_n + 2) done = 1;
      end
      stalled = out_valid && !out_ready;
      sdat = out_data;
      @(posedge clk); #1;
      in_valid  = (idx < n) && ($urandom % 4 != 0);
      in_data   = {1'($urandom), fch[idx]};
      in_last   = (idx == n - 1);
      out_ready = ($urandom % 3 != 0);
    end
    in_valid = 1'b0; in_last = 1'b0; out_ready = 1'b0;
    check(got == exp_n, {"R7 count ", tag}, got, exp_n);
    @(negedge clk);
    check(!out_valid && !in_ready, "R11 idle", int'({out_valid, in_ready}), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [6:0] dna [0:3];
    int r;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    check(!out_valid && !in_ready, "R11 reset", int'({out_valid, in_ready}), 0);
    rst_n = 1'b1;
    tab[0] = "A"; tab[1] = "C"; tab[2] = "G"; tab[3] = "T";
    tab[4] = "0"; tab[5] = "1"; tab[6] = "2"; tab[7] = "A";
    dna[0] = "A"; dna[1] = "C"; dna[2] = "G"; dna[3] = "T";
    // R12, R3: core-only stream, 'A' duplicated and in mid range
    for (int i = 0; i < 16; i++) fch[i] = dna[$urandom % 4];
    run_frame(16, "R12");
    check(exp_n - 12 == 10, "R12 payload bytes", exp_n - 12, 10);
    // R4, R7: mid-tier, byte-aligned end
    fch[0] = "!"; fch[1] = "B"; fch[2] = "_";
    run_frame(3, "R4 aligned");
    // R5: outliers
    fch[0] = "a"; fch[1] = 7'h7F; fch[2] = 7'h00; fch[3] = "z"; fch[4] = 7'h60;
    run_frame(5, "R5");
    // single core char
    fch[0] = "2";
    run_frame(1, "R3 single");
    for (int f = 0; f < 12; f++) begin
      int n = 1 + $urandom % 40;
      for (int i = 0; i < 8; i++) tab[i] = 7'($urandom);
      for (int i = 0; i < n; i++) begin
        r = $urandom % 3;
        fch[i] = (r == 0) ? tab[$urandom % 8] : (r == 1) ? 7'(7'h20 + $urandom % 64) : 7'($urandom);
      end
      run_frame(n, "random");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule